// File: doc/BRIEF.md
# Flash Program Request Checker

This block vets each word that a processor writes toward flash memory while a program sequence is running. It pairs word writes into 64-bit double words, decides for every word whether it breaks a programming rule, and records the outcome in a register of sticky status flags. It also drives a busy indication and two interrupt requests. The array itself is not modelled. Each committed double word keeps the engine busy for a fixed number of cycles, `LAT`.

Two modes are supported. In standard mode, one double word is written at a time. In fast mode, a burst of 16 double words has to stream into a single page. Each next double word must be fully delivered before the one being programmed finishes. Errors are layered: every specific fault also raises the sequence flag, and in fast mode it also raises the fast flag. A flag that is still pending blocks the start of any new request until software clears it.

Top module: `flash_pgm_chk`

## Requirements
- R1: After reset, every status flag, `busy` and `cfg_busy` are 0.
- R2: A write arriving while idle, with neither `pg_en` nor `fast_en` set, raises only the sequence flag (status bit 6). It starts no operation and does not raise the fail flag.
- R3: The program flag (bit 0) is raised on the second word of a double word when `cur_dw` is not all ones and the assembled 64-bit value (second word high, first word low) is not zero.
- R4: The size flag (bit 1) is raised for any program word whose `wr_size` is not word. The size encoding is 0 byte, 1 half-word, 2 word.
- R5: The alignment flag (bit 2) is raised when a word address has a nonzero value in bits [1:0], or when bit 2 differs from the word's position in its double word. In standard mode it is also raised when the second word lies in a different double word from the first. In fast mode it is also raised when a later word leaves the page of the burst's first word.
- R6: The write-protect flag (bit 3) is raised when the page of a word, `wr_addr >> log2(PAGE_BYTES)`, lies inside either protected area. Each area is bounded inclusively by its start and end page, and area k occupies bits [7k+6:7k] of `wp_lo` and `wp_hi`.
- R7: Any specific fault aborts the request: `busy` and `cfg_busy` drop, the sequence flag is raised with the specific flag, and the fail flag (bit 8) is raised when `err_ie` is 1.
- R8: Status flags are sticky. A clear pulse clears the flags selected by `clr_mask` (bit layout as above, done flag bit 7). A flag set in the same cycle wins over its clear.
- R9: On successful completion the done flag (bit 7) is raised only if `eop_ie` is 1. `irq_done` equals done AND `eop_ie`, and `irq_fail` equals fail AND `err_ie`.
- R10: `cfg_busy` rises the cycle after the first accepted word. `busy` rises when a double word is committed and stays high for `LAT` cycles per double word. Both drop together at completion.
- R11: In fast mode (chosen when `fast_en` is 1 at the first word), a burst of 16 double words (32 words) completes with done. Any fault in fast mode also raises the fast flag (bit 5).
- R12: In fast mode, if the next double word is not complete when the current one finishes, the miss flag (bit 4) is raised. A word that would complete a double word while another complete one is already waiting raises the sequence and fast flags. Both cases abort.
- R13: While any of flags 0–6 is set, a new request is refused with the sequence flag only. A word arriving after all words of the current request have been received raises the sequence flag and is dropped, and the running operation continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_en | input | 1 | Standard program enable |
| fast_en | input | 1 | Fast program enable |
| eop_ie | input | 1 | Done interrupt enable |
| err_ie | input | 1 | Fail interrupt enable |
| wr_valid | input | 1 | Memory write strobe |
| wr_addr | input | AW | Byte address of the write |
| wr_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| wr_data | input | 32 | Write data |
| cur_dw | input | 64 | Present contents of the target double word |
| wp_lo | input | NAREA*PW | Start pages of the protected areas |
| wp_hi | input | NAREA*PW | End pages of the protected areas |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 9 | Flags to clear |
| status | output | 9 | Sticky status flags |
| busy | output | 1 | Double word being programmed |
| cfg_busy | output | 1 | Request in progress |
| irq_done | output | 1 | Done interrupt request |
| irq_fail | output | 1 | Fail interrupt request |

## Verification
A corrupted word count or pairing bit first shows up as a wrong alignment or program flag on the very next word, or as a done that arrives at the wrong time. A corrupted programming timer or pending marker shows up within `LAT` cycles, either as a `busy` edge out of place or as a false miss in fast mode. Because every flag is sticky, a single wrong set stays visible at the ports until it is cleared, so a cycle-by-cycle comparison catches it on the cycle after the faulty edge.

// File: rtl/flash_pgm_pkg.sv
`timescale 1ns/1ps
package flash_pgm_pkg;
    localparam int NFLAG    = 9;
    localparam int F_PROG   = 0;
    localparam int F_SIZE   = 1;
    localparam int F_ALIGN  = 2;
    localparam int F_WPROT  = 3;
    localparam int F_MISS   = 4;
    localparam int F_FAST   = 5;
    localparam int F_SEQ    = 6;
    localparam int F_DONE   = 7;
    localparam int F_FAIL   = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;
endpackage

// File: rtl/flash_pgm_wprot.sv
`timescale 1ns/1ps
module flash_pgm_wprot #(
    parameter int PW    = 7,
    parameter int NAREA = 2
) (
    input  logic [PW-1:0]       page,
    input  logic [NAREA*PW-1:0] lo,
    input  logic [NAREA*PW-1:0] hi,
    output logic                hit
);
    logic [NAREA-1:0] in_area;

    for (genvar k = 0; k < NAREA; k++) begin : g_area
        assign in_area[k] = (page >= lo[k*PW +: PW]) && (page <= hi[k*PW +: PW]);
    end

    assign hit = |in_area;
endmodule

// File: rtl/flash_pgm_word_chk.sv
`timescale 1ns/1ps
module flash_pgm_word_chk
    import flash_pgm_pkg::*;
#(
    parameter int AW       = 18,
    parameter int PAGE_LSB = 11,
    localparam int PW      = AW - PAGE_LSB,
    localparam int DWA     = AW - 3
) (
    input  logic [AW-1:0]  addr,
    input  logic [1:0]     size,
    input  logic [31:0]    data_hi,
    input  logic [31:0]    data_lo,
    input  logic [63:0]    cur_dw,
    input  logic           parity,
    input  logic           first,
    input  logic           fast_mode,
    input  logic [DWA-1:0] dw_addr_ref,
    input  logic [PW-1:0]  page_ref,
    output logic           size_err,
    output logic           align_err,
    output logic           prog_err
);
    logic bad_low, bad_half, bad_dw, bad_page;

    always_comb begin
        size_err  = (size != SZ_WORD);
        bad_low   = (addr[1:0] != 2'b00);
        bad_half  = (addr[2] != parity);
        bad_dw    = !first && !fast_mode && (addr[AW-1:3] != dw_addr_ref);
        bad_page  = !first &&  fast_mode && (addr[AW-1:PAGE_LSB] != page_ref);
        align_err = bad_low || bad_half || bad_dw || bad_page;
        prog_err  = parity && (cur_dw != '1) && ({data_hi, data_lo} != 64'd0);
    end
endmodule

// File: rtl/flash_pgm_chk.sv
`timescale 1ns/1ps
module flash_pgm_chk
    import flash_pgm_pkg::*;
#(
    parameter int AW         = 18,
    parameter int PAGE_BYTES = 2048,
    parameter int NAREA      = 2,
    parameter int LAT        = 4,
    parameter int FAST_DWS   = 16,
    localparam int PAGE_LSB  = $clog2(PAGE_BYTES),
    localparam int PW        = AW - PAGE_LSB
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pg_en,
    input  logic                fast_en,
    input  logic                eop_ie,
    input  logic                err_ie,
    input  logic                wr_valid,
    input  logic [AW-1:0]       wr_addr,
    input  logic [1:0]          wr_size,
    input  logic [31:0]         wr_data,
    input  logic [63:0]         cur_dw,
    input  logic [NAREA*PW-1:0] wp_lo,
    input  logic [NAREA*PW-1:0] wp_hi,
    input  logic                clr_valid,
    input  logic [NFLAG-1:0]    clr_mask,
    output logic [NFLAG-1:0]    status,
    output logic                busy,
    output logic                cfg_busy,
    output logic                irq_done,
    output logic                irq_fail
);
    localparam int DWA    = AW - 3;
    localparam int WCNT_W = $clog2(2*FAST_DWS + 1);
    localparam int DCNT_W = $clog2(FAST_DWS + 1);
    localparam int TW     = (LAT > 1) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic [NFLAG-1:0]  flags;
        logic              busy;
        logic              cfg;
        logic              fast;
        logic [WCNT_W-1:0] words;
        logic [DCNT_W-1:0] dws;
        logic              pend;
        logic [TW-1:0]     timer;
        logic [31:0]       first_data;
        logic [DWA-1:0]    dw_addr;
        logic [PW-1:0]     page;
    } state_t;

    state_t s_d, s_q;

    logic          mode_fast, parity, first;
    logic          size_err, align_err, prog_err, wp_hit;
    logic [PW-1:0] page_w;

    assign page_w    = wr_addr[AW-1:PAGE_LSB];
    assign first     = !s_q.cfg;
    assign mode_fast = first ? fast_en : s_q.fast;
    assign parity    = first ? 1'b0 : s_q.words[0];

    flash_pgm_word_chk #(.AW(AW), .PAGE_LSB(PAGE_LSB)) u_word (
        .addr        (wr_addr),
        .size        (wr_size),
        .data_hi     (wr_data),
        .data_lo     (s_q.first_data),
        .cur_dw      (cur_dw),
        .parity      (parity),
        .first       (first),
        .fast_mode   (mode_fast),
        .dw_addr_ref (s_q.dw_addr),
        .page_ref    (s_q.page),
        .size_err    (size_err),
        .align_err   (align_err),
        .prog_err    (prog_err)
    );

    flash_pgm_wprot #(.PW(PW), .NAREA(NAREA)) u_wprot (
        .page (page_w),
        .lo   (wp_lo),
        .hi   (wp_hi),
        .hit  (wp_hit)
    );

    logic [NFLAG-1:0]  set_f;
    logic              abort, finish, done_now, ovf, werr;
    logic [WCNT_W-1:0] total_w;
    logic [DCNT_W-1:0] burst_dw;

    always_comb begin
        s_d      = s_q;
        set_f    = '0;
        abort    = 1'b0;
        finish   = 1'b0;
        total_w  = s_q.fast ? WCNT_W'(2*FAST_DWS) : WCNT_W'(2);
        burst_dw = s_q.fast ? DCNT_W'(FAST_DWS)   : DCNT_W'(1);
        done_now = s_q.busy && (s_q.timer == '0);
        ovf      = mode_fast && parity && s_q.pend;
        werr     = size_err || align_err || prog_err || wp_hit || ovf;

        // programming engine
        if (s_q.busy && !done_now) begin
            s_d.timer = s_q.timer - 1'b1;
        end
        if (done_now) begin
            if (s_q.dws + 1'b1 == burst_dw) begin
                finish = 1'b1;
            end else if (s_q.pend) begin
                s_d.timer = TW'(LAT-1);
                s_d.pend  = 1'b0;
                s_d.dws   = s_q.dws + 1'b1;
            end else begin
                set_f[F_MISS] = 1'b1;
                set_f[F_FAST] = 1'b1;
                set_f[F_SEQ]  = 1'b1;
                abort         = 1'b1;
            end
        end

        // incoming word
        if (wr_valid) begin
            if (first && (!(pg_en || fast_en) || (|s_q.flags[F_SEQ:0]))) begin
                set_f[F_SEQ] = 1'b1;
            end else if (!first && (s_q.words == total_w)) begin
                set_f[F_SEQ] = 1'b1;
            end else if (werr) begin
                set_f[F_SIZE]  = size_err;
                set_f[F_ALIGN] = align_err;
                set_f[F_PROG]  = prog_err;
                set_f[F_WPROT] = wp_hit;
                set_f[F_FAST]  = mode_fast;
                set_f[F_SEQ]   = 1'b1;
                abort          = 1'b1;
            end else begin
                s_d.words = first ? WCNT_W'(1) : s_q.words + 1'b1;
                if (first) begin
                    s_d.cfg  = 1'b1;
                    s_d.fast = fast_en;
                    s_d.page = page_w;
                    s_d.dws  = '0;
                end
                if (!parity) begin
                    s_d.first_data = wr_data;
                    s_d.dw_addr    = wr_addr[AW-1:3];
                end else if (!s_q.busy) begin
                    s_d.busy  = 1'b1;
                    s_d.timer = TW'(LAT-1);
                end else begin
                    s_d.pend = 1'b1;
                end
            end
        end

        if (abort || finish) begin
            s_d.busy  = 1'b0;
            s_d.cfg   = 1'b0;
            s_d.pend  = 1'b0;
            s_d.words = '0;
            s_d.dws   = '0;
        end
        if (abort) begin
            set_f[F_FAIL] = err_ie;
        end else if (finish) begin
            set_f[F_DONE] = eop_ie;
        end

        s_d.flags = (s_q.flags & ~(clr_valid ? clr_mask : '0)) | set_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status   = s_q.flags;
    assign busy     = s_q.busy;
    assign cfg_busy = s_q.cfg;
    assign irq_done = s_q.flags[F_DONE] && eop_ie;
    assign irq_fail = s_q.flags[F_FAIL] && err_ie;
endmodule

// File: rtl/flash_pgm_chk_sva.sv
`timescale 1ns/1ps
module flash_pgm_chk_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [8:0] status,
    input logic       busy,
    input logic       cfg_busy,
    input logic       eop_ie,
    input logic       clr_valid
);
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_BUSY_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        busy |-> cfg_busy); // R10

    AST_IDLE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $fell(busy) |-> !cfg_busy); // R10

    AST_PRIMARY_RAISES_SEQ: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (|(status[5:0] & ~$past(status[5:0]))) |-> status[6]); // R7

    AST_MISS_WITH_FAST: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (status[4] && !$past(status[4])) |-> status[5]); // R12

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        !$past(clr_valid) |-> ((status & $past(status)) == $past(status))); // R8

    AST_DONE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (status[7] && !$past(status[7])) |-> $past(eop_ie)); // R9
endmodule

bind flash_pgm_chk flash_pgm_chk_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .status    (status),
    .busy      (busy),
    .cfg_busy  (cfg_busy),
    .eop_ie    (eop_ie),
    .clr_valid (clr_valid)
);

// File: tb/sim_flash_pgm_chk.sv
`timescale 1ns/1ps
module sim_flash_pgm_chk;
    localparam int AW  = 18;
    localparam int LAT = 4;
    localparam int PW  = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pg_en = 0, fast_en = 0, eop_ie = 0, err_ie = 0;
    logic          wr_valid = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [1:0]    wr_size = 2'd2;
    logic [31:0]   wr_data = '0;
    logic [63:0]   cur_dw = '1;
    logic [13:0]   wp_lo, wp_hi;
    logic          clr_valid = 0;
    logic [8:0]    clr_mask = '0;
    logic [8:0]    status;
    logic          busy, cfg_busy, irq_done, irq_fail;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // areas: A pages 20..25, B page 40 only
    assign wp_lo = {7'd40, 7'd20};
    assign wp_hi = {7'd40, 7'd25};

    flash_pgm_chk #(.AW(AW), .LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .fast_en(fast_en),
        .eop_ie(eop_ie), .err_ie(err_ie), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .cur_dw(cur_dw), .wp_lo(wp_lo), .wp_hi(wp_hi),
        .clr_valid(clr_valid), .clr_mask(clr_mask), .status(status),
        .busy(busy), .cfg_busy(cfg_busy), .irq_done(irq_done),
        .irq_fail(irq_fail)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_flags, m_words, m_dws, m_timer, m_page, m_dwaddr;
    bit m_busy, m_cfg, m_fast, m_pend;
    logic [31:0] m_lo;

    function automatic bit protected_page(int pg);
        return (pg >= 20 && pg <= 25) || (pg == 40);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flags = 0; m_words = 0; m_dws = 0; m_timer = 0; m_page = 0;
            m_dwaddr = 0; m_busy = 0; m_cfg = 0; m_fast = 0; m_pend = 0; m_lo = 0;
        end else begin
            int  setv, pg, idx, need, nw, nd, nt, np, npg, ndwa;
            bit  abort, fin, fm, par, e_sz, e_al, e_pr, e_wp, e_ov, nb, nc, nf;
            logic [31:0] nlo;
            setv = 0; abort = 0; fin = 0;
            nw = m_words; nd = m_dws; nt = m_timer; np = m_pend; nb = m_busy;
            nc = m_cfg; nf = m_fast; nlo = m_lo; npg = m_page; ndwa = m_dwaddr;
            pg = int'(wr_addr) / 2048;
            need = m_fast ? 16 : 1;
            if (m_busy && m_timer > 0) nt = m_timer - 1;
            if (m_busy && m_timer == 0) begin
                if (m_dws + 1 == need) fin = 1;
                else if (m_pend) begin nt = LAT - 1; np = 0; nd = m_dws + 1; end
                else begin setv |= 9'h070; abort = 1; end
            end
            if (wr_valid) begin
                idx = m_cfg ? m_words : 0;
                fm  = m_cfg ? m_fast : fast_en;
                par = idx % 2;
                if (!m_cfg && (!(pg_en || fast_en) || (m_flags & 9'h07F) != 0))
                    setv |= 9'h040;
                else if (m_cfg && m_words == 2 * need)
                    setv |= 9'h040;
                else begin
                    e_sz = (wr_size != 2'd2);
                    e_al = (wr_addr % 4 != 0) || (((wr_addr / 4) % 2) != par);
                    if (idx > 0 && !fm && int'(wr_addr) / 8 != m_dwaddr) e_al = 1;
                    if (idx > 0 && fm && pg != m_page) e_al = 1;
                    e_pr = par && (cur_dw != {64{1'b1}}) && (wr_data != 0 || m_lo != 0);
                    e_wp = protected_page(pg);
                    e_ov = fm && par && m_pend;
                    if (e_sz || e_al || e_pr || e_wp || e_ov) begin
                        setv |= 9'h040 | (e_pr ? 1 : 0) | (e_sz ? 2 : 0) | (e_al ? 4 : 0)
                              | (e_wp ? 8 : 0) | (fm ? 32 : 0);
                        abort = 1;
                    end else begin
                        nw = idx + 1;
                        if (!m_cfg) begin nc = 1; nf = fast_en; npg = pg; nd = 0; end
                        if (!par) begin nlo = wr_data; ndwa = int'(wr_addr) / 8; end
                        else if (!m_busy) begin nb = 1; nt = LAT - 1; end
                        else np = 1;
                    end
                end
            end
            if (abort || fin) begin nb = 0; nc = 0; np = 0; nw = 0; nd = 0; end
            if (abort && err_ie) setv |= 9'h100;
            if (!abort && fin && eop_ie) setv |= 9'h080;
            if (clr_valid) m_flags = m_flags & ~int'(clr_mask);
            m_flags = m_flags | setv;
            m_words = nw; m_dws = nd; m_timer = nt; m_pend = np; m_busy = nb;
            m_cfg = nc; m_fast = nf; m_lo = nlo; m_page = npg; m_dwaddr = ndwa;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            checks++;
            if (status !== 9'(m_flags) || busy !== m_busy || cfg_busy !== m_cfg ||
                irq_done !== (m_flags[7] && eop_ie) || irq_fail !== (m_flags[8] && err_ie)) begin
                fails++;
                $display("FAIL model compare (R7 R8 R9 R10 R11 R12 R13) t=%0t: status=%h busy=%b cfg=%b expected status=%h busy=%b cfg=%b",
                         $time, status, busy, cfg_busy, 9'(m_flags), m_busy, m_cfg);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic [63:0] cur);
        @(negedge clk);
        clr_valid = 0; wr_valid = 1; wr_addr = a; wr_size = sz; wr_data = d; cur_dw = cur;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid = 0; clr_valid = 0;
        end
    endtask

    task automatic clr(input logic [8:0] m);
        @(negedge clk);
        wr_valid = 0; clr_valid = 1; clr_mask = m;
        @(negedge clk);
        clr_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle(1);
        chk("R1 status", status, 0);
        chk("R1 busy", {busy, cfg_busy}, 0);

        // R2: write with no enable
        wr(18'h00100, 2'd2, 32'h1, '1); idle(1);
        chk("R2 seq only", status, 9'h040);
        chk("R2 no start", cfg_busy, 0);
        // R8: write-one-to-clear
        clr(9'h040);
        chk("R8 cleared", status, 0);

        // R10 / R9: standard success on page 10
        pg_en = 1; eop_ie = 1; err_ie = 1;
        wr(18'h05000, 2'd2, 32'hA5A5_0001, '1); idle(1);
        chk("R10 cfg after first", {busy, cfg_busy}, 2'b01);
        wr(18'h05004, 2'd2, 32'h5A5A_0002, '1); idle(1);
        chk("R10 busy on commit", {busy, cfg_busy}, 2'b11);
        idle(3);
        chk("R10 busy lasts LAT", busy, 1);
        idle(1);
        chk("R10 busy ends", {busy, cfg_busy}, 2'b00);
        chk("R9 done flag", status, 9'h080);
        chk("R9 irq_done", irq_done, 1);
        clr(9'h1FF);

        // R3: non-erased target, nonzero data
        wr(18'h05008, 2'd2, 32'h1, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(18'h0500C, 2'd2, 32'h2, 64'hFFFF_FFFF_FFFF_FFFE); idle(1);
        chk("R3 prog error", status, 9'h141);
        chk("R7 abort idle", {busy, cfg_busy}, 0);
        chk("R9 irq_fail", irq_fail, 1);
        clr(9'h1FF);
        // R3: zero data into non-erased target is fine
        wr(18'h05010, 2'd2, 32'h0, 64'h0123_4567_89AB_CDEF);
        wr(18'h05014, 2'd2, 32'h0, 64'h0123_4567_89AB_CDEF); idle(6);
        chk("R3 zero data accepted", status, 9'h080);
        clr(9'h1FF);

        // R4: half-word access
        wr(18'h05018, 2'd1, 32'h3, '1); idle(1);
        chk("R4 size error", status, 9'h142);
        clr(9'h1FF);

        // R5: second word in another double word
        wr(18'h05020, 2'd2, 32'h4, '1);
        wr(18'h05028, 2'd2, 32'h5, '1); idle(1);
        chk("R5 align error", status, 9'h144);
        clr(9'h1FF);

        // R6: protected pages, inclusive ends
        wr(18'(25 * 2048), 2'd2, 32'h6, '1); idle(1);
        chk("R6 area A end page", status, 9'h148);
        clr(9'h1FF);
        wr(18'(40 * 2048 + 16), 2'd2, 32'h7, '1); idle(1);
        chk("R6 area B single page", status, 9'h148);
        clr(9'h1FF);
        wr(18'(26 * 2048), 2'd2, 32'h8, '1); idle(1);
        chk("R6 page past area accepted", cfg_busy, 1);
        wr(18'(26 * 2048 + 4), 2'd2, 32'h9, '1); idle(6);
        chk("R6 unprotected completes", status, 9'h080);
        clr(9'h1FF);

        // R13: pending flag blocks a new request
        pg_en = 0;
        wr(18'h05100, 2'd2, 32'h1, '1); idle(1);
        pg_en = 1;
        wr(18'h05100, 2'd2, 32'h1, '1); idle(1);
        chk("R13 refused while flag pending", {status, cfg_busy}, {9'h040, 1'b0});
        clr(9'h1FF);
        // R13: extra word after the double word
        wr(18'h05200, 2'd2, 32'h1, '1);
        wr(18'h05204, 2'd2, 32'h2, '1);
        wr(18'h05208, 2'd2, 32'h3, '1); idle(1);
        chk("R13 extra word keeps op", {status, busy}, {9'h040, 1'b1});
        idle(5);
        chk("R13 op still completes", status, 9'h0C0);
        clr(9'h1FF);

        // R9: enables off
        eop_ie = 0;
        wr(18'h05300, 2'd2, 32'h1, '1);
        wr(18'h05304, 2'd2, 32'h2, '1); idle(6);
        chk("R9 no done without enable", status, 0);
        err_ie = 0;
        wr(18'h05308, 2'd2, 32'h1, 64'h0);
        wr(18'h0530C, 2'd2, 32'h2, 64'h0); idle(1);
        chk("R9 no fail without enable", {status, irq_fail}, {9'h001 | 9'h040, 1'b0});
        clr(9'h1FF);
        eop_ie = 1; err_ie = 1;

        // R11: fast burst of 16 double words on page 30
        pg_en = 0; fast_en = 1;
        for (int k = 0; k < 16; k++) begin
            if (k >= 2) idle(2);
            wr(18'(30 * 2048 + 8 * k), 2'd2, 32'(2 * k + 1), '1);
            wr(18'(30 * 2048 + 8 * k + 4), 2'd2, 32'(2 * k + 2), '1);
        end
        idle(1);
        chk("R11 busy during burst", busy, 1);
        idle(11);
        chk("R11 burst done", {status, busy, cfg_busy}, {9'h080, 2'b00});
        clr(9'h1FF);

        // R12: data miss after two double words
        for (int k = 0; k < 4; k++) wr(18'(30 * 2048 + 4 * k), 2'd2, 32'h1, '1);
        idle(10);
        chk("R12 miss error", status, 9'h170);
        clr(9'h1FF);
        // R12: double word arriving while one already waits
        for (int k = 0; k < 6; k++) wr(18'(30 * 2048 + 4 * k), 2'd2, 32'h1, '1);
        idle(1);
        chk("R12 overflow error", {status, busy}, {9'h160, 1'b0});
        clr(9'h1FF);
        // R11: page change in fast mode
        wr(18'(30 * 2048), 2'd2, 32'h1, '1);
        wr(18'(31 * 2048 + 4), 2'd2, 32'h2, '1); idle(1);
        chk("R11 fast page change", status, 9'h164);
        // R8: set wins over a same-cycle clear
        fast_en = 0;
        @(negedge clk);
        wr_valid = 1; wr_addr = 18'h00100; clr_valid = 1; clr_mask = 9'h1FF;
        idle(1);
        chk("R8 set beats clear", status, 9'h040);

        idle(2);
        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule